// File: doc/BRIEF.md
# Virtual-Lane Block Distributor with Alignment Markers

This block sits on the transmit side of a multi-lane physical coding stage. It accepts a stream of already scrambled 66-bit blocks, one block per clock, and spreads them across a set of virtual lanes. The first block of a group goes to lane 0, the next to lane 1, and so on. When every lane holds one block, the complete group is presented on the lane outputs for one cycle under a single valid strobe.

At a fixed spacing, counted in groups, the block stops taking input for one cycle and emits a marker group instead. In a marker group every lane carries its own fixed alignment block, and all lanes carry it in the same cycle. A receiver uses these blocks to find lane identity and to remove skew between lanes. The marker spacing ignores packet framing, so a marker can land in the middle of a payload. The upstream source sees this only as one cycle of deasserted ready. The lane count is a parameter and takes one of two legal values: 4 for the 40G configuration and 20 for the 100G configuration. Any other value stops elaboration.

Top module: `vlane_distributor`

## Requirements
- R1: Accepted blocks (in_valid and in_ready both high at a clock edge) fill the lanes in strict order. The first block of a group appears on lane 0 (out_lanes bits [65:0]), and the block accepted k-th appears on lane k (bits [k*66+65:k*66]).
- R2: A data group appears with out_valid high for exactly one cycle, in the cycle after its last block is accepted. No group appears twice and none is dropped.
- R3: Each block crosses unchanged, including its 2-bit sync header in bits [65:64] of the block.
- R4: In a marker group, lane i carries {2'b10, 48'h4B1ED07A93C6, i[7:0], ~i[7:0]}. The sync header is 2'b10 in bits [65:64], and the lane index sits in bits [15:8] with its complement in bits [7:0].
- R5: Between two consecutive marker groups there are exactly PERIOD data groups, whatever the block contents. The default PERIOD is 16384.
- R6: in_ready is low for exactly one cycle per marker group, the cycle in which that marker is issued, and is high in every other cycle out of reset. A block offered while in_ready is low is not taken.
- R7: While reset is high, out_valid and in_ready are low. The first output group after reset is a marker group, issued in the first cycle after reset falls, and the lane pointer starts at lane 0.
- R8: The first block accepted after a marker group goes to lane 0.
- R9: With LANES = 20, the marker group carries all twenty lane-specific markers in one cycle. LANES must be 4 or 20.
- R10: Cycles with in_valid low move neither the lane pointer nor the group count. A partly filled group produces no output until its remaining blocks arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input block is valid |
| in_ready | output | 1 | Block can be accepted this cycle |
| in_blk | input | 66 | Input block: sync header in [65:64], payload in [63:0] |
| out_valid | output | 1 | Lane outputs carry a group this cycle |
| out_lanes | output | LANES*66 | Lane i occupies bits [i*66+65:i*66] |

## Verification
The two events that collide are the completion of the last data group in a marker period and the marker that becomes due right after it. The bench provokes the collision by keeping in_valid high through it. The block offered in the following cycle then meets a low ready. It must be held back, appear on lane 0 of the group after the marker, and never be duplicated. A scoreboard fed by the driver's model of period and lane order checks the result: every cycle's ready level is compared against the model, and every emitted group, marker or data, is compared against the queue.

// File: rtl/vlane_pkg.sv
package vlane_pkg;

   localparam int BLK_W = 66;

   typedef logic [BLK_W-1:0] blk_t;

   localparam logic [1:0]  MARK_HDR  = 2'b10;
   localparam logic [47:0] MARK_BODY = 48'h4B1E_D07A_93C6;

   // Lane-specific alignment block: fixed body, lane index and its complement
   function automatic blk_t mark_block(input int unsigned idx);
      logic [7:0] tag;
      tag = idx[7:0];
      return {MARK_HDR, MARK_BODY, tag, ~tag};
   endfunction

endpackage

// File: rtl/vlane_pacer.sv
module vlane_pacer
   import vlane_pkg::*;
#(
   parameter int PERIOD = 16384
) (
   input  logic clk,
   input  logic rst,
   input  logic grp_done,
   output logic mark_due
);

   localparam int CNT_W = (PERIOD > 1) ? $clog2(PERIOD) : 1;
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PERIOD - 1);

   generate
      if (PERIOD < 1) begin : g_bad_period
         $error("vlane_pacer: PERIOD must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0] grp_cnt;

   // A due marker is always issued in the cycle it is due
   always_ff @(posedge clk) begin
      if (rst) begin
         grp_cnt  <= '0;
         mark_due <= 1'b1;
      end else if (mark_due) begin
         mark_due <= 1'b0;
      end else if (grp_done) begin
         if (grp_cnt == CNT_LAST) begin
            grp_cnt  <= '0;
            mark_due <= 1'b1;
         end else begin
            grp_cnt <= grp_cnt + 1'b1;
         end
      end
   end

   AST_MARK_SINGLE: assert property (@(posedge clk) disable iff (rst)
      mark_due |=> !mark_due);                                   // R6

   AST_CNT_IDLE: assert property (@(posedge clk) disable iff (rst)
      (!grp_done && !mark_due) |=> $stable(grp_cnt));            // R10

endmodule

// File: rtl/vlane_dealer.sv
module vlane_dealer
   import vlane_pkg::*;
#(
   parameter int LANES = 4
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   take,
   input  blk_t                   blk_in,
   output logic                   grp_done,
   output logic [LANES*BLK_W-1:0] grp_vec
);

   localparam int PTR_W = $clog2(LANES);
   localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(LANES - 1);

   logic [PTR_W-1:0] ptr;

   always_ff @(posedge clk) begin
      if (rst)
         ptr <= '0;
      else if (take)
         ptr <= (ptr == PTR_LAST) ? '0 : ptr + 1'b1;
   end

   // Holding slots for all lanes but the last; the last lane takes the
   // closing block straight from the input
   generate
      for (genvar g = 0; g < LANES - 1; g++) begin : g_slot
         blk_t slot;
         always_ff @(posedge clk) begin
            if (take && ptr == PTR_W'(g))
               slot <= blk_in;
         end
         assign grp_vec[g*BLK_W +: BLK_W] = slot;
      end
   endgenerate

   assign grp_vec[(LANES-1)*BLK_W +: BLK_W] = blk_in;
   assign grp_done = take && (ptr == PTR_LAST);

   AST_PTR_HOLD: assert property (@(posedge clk) disable iff (rst)
      !take |=> $stable(ptr));                                   // R10

   AST_PTR_WRAP: assert property (@(posedge clk) disable iff (rst)
      grp_done |=> (ptr == '0));                                 // R8

endmodule

// File: rtl/vlane_marks.sv
module vlane_marks
   import vlane_pkg::*;
#(
   parameter int LANES = 4
) (
   output logic [LANES*BLK_W-1:0] marks
);

   generate
      for (genvar g = 0; g < LANES; g++) begin : g_mark
         assign marks[g*BLK_W +: BLK_W] = mark_block(g);
      end
   endgenerate

endmodule

// File: rtl/vlane_distributor.sv
module vlane_distributor
   import vlane_pkg::*;
#(
   parameter int LANES  = 4,
   parameter int PERIOD = 16384
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   in_valid,
   output logic                   in_ready,
   input  logic [BLK_W-1:0]       in_blk,
   output logic                   out_valid,
   output logic [LANES*BLK_W-1:0] out_lanes
);

   localparam int GRP_W = LANES * BLK_W;
   localparam int DS_W  = $clog2(PERIOD + 2);

   generate
      if (LANES != 4 && LANES != 20) begin : g_bad_lanes
         $error("vlane_distributor: LANES must be 4 or 20");
      end
   endgenerate

   logic             mark_due;
   logic             take;
   logic             grp_done;
   logic [GRP_W-1:0] grp_vec;
   logic [GRP_W-1:0] marks;

   assign in_ready = !mark_due && !rst;
   assign take     = in_valid && in_ready;

   vlane_pacer #(.PERIOD(PERIOD)) u_pacer (
      .clk      (clk),
      .rst      (rst),
      .grp_done (grp_done),
      .mark_due (mark_due)
   );

   vlane_dealer #(.LANES(LANES)) u_dealer (
      .clk      (clk),
      .rst      (rst),
      .take     (take),
      .blk_in   (in_blk),
      .grp_done (grp_done),
      .grp_vec  (grp_vec)
   );

   vlane_marks #(.LANES(LANES)) u_marks (
      .marks (marks)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
         out_lanes <= '0;
      end else if (mark_due) begin
         out_valid <= 1'b1;
         out_lanes <= marks;
      end else if (grp_done) begin
         out_valid <= 1'b1;
         out_lanes <= grp_vec;
      end else begin
         out_valid <= 1'b0;
      end
   end

   // Observation state for the properties below
   logic            is_mark;
   logic            seen_out;
   logic [DS_W-1:0] data_since;

   assign is_mark = (out_lanes == marks);

   always_ff @(posedge clk) begin
      if (rst) begin
         seen_out   <= 1'b0;
         data_since <= '0;
      end else if (out_valid) begin
         seen_out   <= 1'b1;
         data_since <= is_mark ? '0 : data_since + 1'b1;
      end
   end

   AST_FIRST_IS_MARK: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !seen_out) |-> is_mark);                     // R7

   AST_STALL_GIVES_MARK: assert property (@(posedge clk) disable iff (rst)
      !in_ready |=> (out_valid && is_mark));                     // R4

   AST_MARK_SPACING: assert property (@(posedge clk) disable iff (rst)
      (out_valid && is_mark && seen_out) |-> (data_since == DS_W'(PERIOD))); // R5

   AST_GROUP_PULSE: assert property (@(posedge clk) disable iff (rst)
      grp_done |=> (out_valid && !is_mark));                     // R2

   AST_HDR_KEPT: assert property (@(posedge clk) disable iff (rst)
      grp_done |=> (out_lanes[GRP_W-1 -: 2] == $past(in_blk[BLK_W-1 -: 2]))); // R3

endmodule

// File: tb/vlane_distributor_tb.sv
module vlane_distributor_tb;
   import vlane_pkg::*;

   localparam int LN  = 4;
   localparam int PER = 3;
   localparam int W   = LN * 66;
   localparam int BW  = 20 * 66;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #4 clk = ~clk;

   logic          in_valid = 1'b0;
   logic [65:0]   in_blk   = '0;
   logic          in_ready, out_valid;
   logic [W-1:0]  out_lanes;

   logic          r20_ready, r20_valid;
   logic [BW-1:0] r20_lanes;

   vlane_distributor #(.LANES(LN), .PERIOD(PER)) u_dut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
      .in_blk(in_blk), .out_valid(out_valid), .out_lanes(out_lanes));

   vlane_distributor #(.LANES(20), .PERIOD(2)) u_dut20 (
      .clk(clk), .rst(rst), .in_valid(1'b0), .in_ready(r20_ready),
      .in_blk(66'd0), .out_valid(r20_valid), .out_lanes(r20_lanes));

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   logic [W-1:0] expq[$];
   logic [W-1:0] stage_v = '0;
   int           m_ptr = 0;
   int           m_grp = 0;
   bit           pend  = 1;
   logic [63:0]  lcg   = 64'h0123_4567_89AB_CDEF;

   function automatic logic [65:0] exp_mark(input int i);
      logic [7:0] t;
      t = 8'(i);
      return {2'b10, 48'h4B1ED07A93C6, t, ~t};
   endfunction

   function automatic logic [W-1:0] mark_grp();
      logic [W-1:0] v;
      for (int i = 0; i < LN; i++) v[i*66 +: 66] = exp_mark(i);
      return v;
   endfunction

   task automatic chk(input bit ok, input string tag,
                      input logic [BW-1:0] act, input logic [BW-1:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [65:0] next_blk(input logic [1:0] hdr);
      lcg = lcg * 64'd6364136223846793005 + 64'd1442695040888963407;
      return {hdr, lcg};
   endfunction

   // Model update for one clock edge (R1, R5, R6, R8)
   task automatic model_edge(input bit v, input logic [65:0] b);
      if (pend) begin
         pend = 0;
      end else if (v) begin
         stage_v[m_ptr*66 +: 66] = b;
         m_ptr++;
         if (m_ptr == LN) begin
            expq.push_back(stage_v);
            m_ptr = 0;
            m_grp++;
            if (m_grp == PER) begin
               m_grp = 0;
               pend  = 1;
               expq.push_back(mark_grp());
            end
         end
      end
   endtask

   task automatic send(input logic [65:0] b);
      bit took;
      do begin
         @(negedge clk);
         chk(in_ready == !pend, "R6 ready", BW'(in_ready), BW'(!pend));
         in_valid = 1'b1;
         in_blk   = b;
         @(posedge clk);
         took = !pend;
         model_edge(1'b1, b);
      end while (!took);
   endtask

   task automatic idle(input int n, input bit quiet);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         chk(in_ready == !pend, "R6 ready", BW'(in_ready), BW'(!pend));
         if (quiet && k >= 2)
            chk(out_valid == 1'b0, "R10 idle output", BW'(out_valid), BW'(0));
         in_valid = 1'b0;
         @(posedge clk);
         model_edge(1'b0, '0);
      end
   endtask

   // Monitor / scoreboard
   bit first_out  = 1;
   bit after_mark = 0;
   int ds         = 0;
   int marks_seen = 0;

   always @(negedge clk) begin
      if (!rst && out_valid) begin
         if (expq.size() == 0) begin
            chk(1'b0, "R2 unexpected group", BW'(out_lanes), '0);
         end else begin
            logic [W-1:0] e;
            bit           act_mark;
            string        tag;
            e = expq.pop_front();
            act_mark = (out_lanes == mark_grp());
            if (first_out)            tag = "R7 first group";
            else if (e == mark_grp()) tag = "R4 marker group";
            else if (after_mark)      tag = "R8 group after marker";
            else                      tag = "R1 data group";
            chk(out_lanes == e, tag, BW'(out_lanes), BW'(e));
            if (e != mark_grp()) begin
               for (int i = 0; i < LN; i++)
                  chk(out_lanes[i*66+64 +: 2] == e[i*66+64 +: 2], "R3 header",
                      BW'(out_lanes[i*66+64 +: 2]), BW'(e[i*66+64 +: 2]));
            end
            if (act_mark) begin
               if (!first_out)
                  chk(ds == PER, "R5 spacing", BW'(ds), BW'(PER));
               ds = 0;
               marks_seen++;
            end else begin
               ds++;
            end
            after_mark = act_mark;
            first_out  = 0;
         end
      end
   end

   // Twenty-lane variant: first group after reset is the full marker set
   initial begin
      logic [BW-1:0] m20;
      for (int i = 0; i < 20; i++) m20[i*66 +: 66] = exp_mark(i);
      @(negedge rst);
      @(posedge clk);
      @(negedge clk);
      chk(r20_valid == 1'b1, "R9 valid", BW'(r20_valid), BW'(1));
      chk(r20_lanes == m20, "R9 twenty markers", r20_lanes, m20);
      chk(r20_ready == 1'b1, "R9 ready after marker", BW'(r20_ready), BW'(1));
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) begin
         @(negedge clk);
         chk(out_valid == 1'b0, "R7 reset valid", BW'(out_valid), BW'(0));
         chk(in_ready == 1'b0, "R7 reset ready", BW'(in_ready), BW'(0));
      end
      expq.push_back(mark_grp());
      @(negedge clk);
      rst = 1'b0;
      chk(in_ready == 1'b0, "R6 ready at first marker", BW'(in_ready), BW'(0));
      @(posedge clk);
      model_edge(1'b0, '0);

      // Back-to-back stream crossing marker boundaries
      for (int i = 0; i < 30; i++) send(next_blk(2'b01));
      // Partial group held across idle cycles
      send(next_blk(2'b10));
      idle(5, 1'b1);
      // Gapped stream with mixed headers
      for (int i = 0; i < 40; i++) begin
         send(next_blk((i % 2 == 0) ? 2'b01 : 2'b10));
         idle(i % 3, 1'b0);
      end
      idle(6, 1'b0);
      chk(expq.size() == 0, "R2 all groups delivered", BW'(expq.size()), BW'(0));
      chk(marks_seen >= 4, "R5 markers observed", BW'(marks_seen), BW'(4));
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

endmodule